// File: doc/BRIEF.md
# Counter-Mode Block Incrementer

This block advances a counter that lives inside a 128-bit data block, as used between block-cipher passes in counter mode. The block is seen as 16 octets, octet 0 being bits 7:0. Three run-time controls choose the counter: a size code sets its width, an alignment bit places it in the low or high half of the block, and an endianness bit sets which way the carry runs. On an increment strobe the block takes the input value, adds one to the counter field, and registers the result. Every octet outside the field is copied through unchanged.

The surrounding controller decides when to increment and what to do with the result. It presents the current block and the controls, pulses the strobe for one cycle, and collects the updated block one cycle later, when the done flag is high. A disabled or unsupported size code makes the strobe do nothing. While the counter is enabled and the engine is busy, the controller must block writes to the block value, either by dropping them or by stalling the bus.

Top module: `ctr_block_incr`

## Requirements
- R1: The size code `ctr_size` selects the counter width. Code 1 is 1 octet, 2 is 2 octets, 3 is 4 octets, 4 is 8 octets and 5 is 16 octets. Code 0 disables the counter.
- R2: With size code 0, 6 or 7, a strobe is ignored. `blk_out` keeps its previous value and `inc_done` stays low.
- R3: With `ctr_right`=0 and a width of N<16 octets, the counter occupies octets 0 to N-1.
- R4: With `ctr_right`=1 and a width of N<16 octets, the counter occupies octets 16-N to 15.
- R5: With size code 5, `ctr_right` has no effect and all 16 octets form the counter.
- R6: With `ctr_big`=0, the lowest-numbered octet of the field is least significant, and the carry runs from octet n to octet n+1.
- R7: With `ctr_big`=1, the highest-numbered octet of the field is least significant, and the carry runs from octet n to octet n-1.
- R8: The counter wraps to zero inside its field. No carry leaves the field, and every octet outside the field equals the input octet.
- R9: After a strobe with a valid size, `blk_out` holds the incremented value and `inc_done` is high in the next cycle. At all other times `inc_done` is low.
- R10: Reset drives `blk_out` to zero and `inc_done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_in | input | 128 | Block value holding the counter |
| ctr_size | input | 3 | Counter size code |
| ctr_right | input | 1 | 1: counter in the high octets; 0: counter in the low octets |
| ctr_big | input | 1 | 1: carry runs toward lower octet numbers |
| inc_req | input | 1 | One-cycle increment strobe |
| blk_out | output | 128 | Registered updated block |
| inc_done | output | 1 | High for one cycle when blk_out holds a new result |

## Verification
A wrong field mask shows at the ports in the cycle after the strobe. It appears as a changed octet outside the field, or as an unchanged octet inside the field where the carry should have reached it. A wrong carry direction or carry start shows in that same cycle as a wrong increment, and all-ones inputs make it obvious because the whole field must wrap to zero. A valid flag that stays high for codes 6 and 7 shows as a done pulse or a changed output where the output should have held. The reference model walks the octets in order of significance and shares no structure with the design's forward and backward carry chains.

// File: rtl/ctr_incr_pkg.sv
package ctr_incr_pkg;
  localparam int OCT_W = 8;

  typedef enum logic [2:0] {
    SZ_OFF = 3'd0,
    SZ_8   = 3'd1,
    SZ_16  = 3'd2,
    SZ_32  = 3'd3,
    SZ_64  = 3'd4,
    SZ_128 = 3'd5
  } ctr_size_e;

  // number of counter octets for a size code; 0 means disabled or unsupported
  function automatic int unsigned field_octets(input logic [2:0] code);
    case (code)
      SZ_8:    field_octets = 1;
      SZ_16:   field_octets = 2;
      SZ_32:   field_octets = 4;
      SZ_64:   field_octets = 8;
      SZ_128:  field_octets = 16;
      default: field_octets = 0;
    endcase
  endfunction
endpackage

// File: rtl/ctr_field_decode.sv
module ctr_field_decode
  import ctr_incr_pkg::*;
#(
  parameter int OCTETS = 16
) (
  input  logic [2:0]        size_code,
  input  logic              right_align,
  output logic [OCTETS-1:0] field_en,
  output logic              field_valid
);
  int unsigned n_oct;
  int unsigned lo_oct;

  always_comb begin
    n_oct       = field_octets(size_code);
    field_valid = (n_oct != 0) && (n_oct <= OCTETS);
    // a full-width counter has no alignment
    lo_oct      = (right_align && n_oct < OCTETS) ? (OCTETS - n_oct) : 0;
    for (int i = 0; i < OCTETS; i++) begin
      field_en[i] = field_valid && (i >= lo_oct) && (i < lo_oct + n_oct);
    end
  end
endmodule

// File: rtl/ctr_carry_chain.sv
module ctr_carry_chain
  import ctr_incr_pkg::*;
#(
  parameter int OCTETS = 16,
  localparam int BLK_W = OCTETS * OCT_W
) (
  input  logic [BLK_W-1:0]  data,
  input  logic [OCTETS-1:0] field_en,
  input  logic              big_endian,
  output logic [BLK_W-1:0]  data_inc
);
  logic [OCTETS-1:0] all_ones;
  logic [OCTETS-1:0] up_carry;
  logic [OCTETS-1:0] dn_carry;
  logic [OCTETS-1:0] bump;

  for (genvar g = 0; g < OCTETS; g++) begin : g_oct
    assign all_ones[g] = &data[g*OCT_W +: OCT_W];
    assign data_inc[g*OCT_W +: OCT_W] = data[g*OCT_W +: OCT_W] + OCT_W'(bump[g]);
  end

  // carry toward higher octets: the field's first octet always takes the +1
  always_comb begin
    up_carry[0] = field_en[0];
    for (int i = 1; i < OCTETS; i++) begin
      up_carry[i] = field_en[i] & (~field_en[i-1] | (up_carry[i-1] & all_ones[i-1]));
    end
  end

  // carry toward lower octets: the field's last octet always takes the +1
  always_comb begin
    dn_carry[OCTETS-1] = field_en[OCTETS-1];
    for (int i = OCTETS - 2; i >= 0; i--) begin
      dn_carry[i] = field_en[i] & (~field_en[i+1] | (dn_carry[i+1] & all_ones[i+1]));
    end
  end

  assign bump = big_endian ? dn_carry : up_carry;
endmodule

// File: rtl/ctr_block_incr.sv
module ctr_block_incr
  import ctr_incr_pkg::*;
#(
  parameter int OCTETS = 16,
  localparam int BLK_W = OCTETS * OCT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BLK_W-1:0] blk_in,
  input  logic [2:0]       ctr_size,
  input  logic             ctr_right,
  input  logic             ctr_big,
  input  logic             inc_req,
  output logic [BLK_W-1:0] blk_out,
  output logic             inc_done
);
  logic [OCTETS-1:0] field_en;
  logic              field_valid;
  logic [BLK_W-1:0]  blk_inc;
  logic [BLK_W-1:0]  field_bits;
  logic [BLK_W-1:0]  out_q, out_d;
  logic              done_q, done_d;
  logic              load_en;

  ctr_field_decode #(.OCTETS(OCTETS)) u_decode (
    .size_code   (ctr_size),
    .right_align (ctr_right),
    .field_en    (field_en),
    .field_valid (field_valid)
  );

  ctr_carry_chain #(.OCTETS(OCTETS)) u_chain (
    .data       (blk_in),
    .field_en   (field_en),
    .big_endian (ctr_big),
    .data_inc   (blk_inc)
  );

  for (genvar g = 0; g < OCTETS; g++) begin : g_mask
    assign field_bits[g*OCT_W +: OCT_W] = {OCT_W{field_en[g]}};
  end

  // next state
  always_comb begin
    load_en = inc_req & field_valid;
    out_d   = blk_inc;
    done_d  = load_en;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
      if (load_en) out_q <= out_d;
    end
  end

  assign blk_out  = out_q;
  assign inc_done = done_q;

  assert_ignore_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_req && (ctr_size == 3'd0 || ctr_size > 3'd5)) |=> ($stable(blk_out) && !inc_done));

  assert_left_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctr_right && ctr_size >= 3'd1 && ctr_size <= 3'd4) |-> (field_en[OCTETS-1:OCTETS/2] == '0));

  assert_right_half_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctr_right && ctr_size >= 3'd1 && ctr_size <= 3'd4) |-> (field_en[OCTETS/2-1:0] == '0));

  assert_full_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctr_size == 3'd5) |-> (&field_en));

  assert_outside_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_req && field_valid) |=> (((blk_out ^ $past(blk_in)) & ~$past(field_bits)) == '0));

  assert_value_moves_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_req && field_valid) |=> (blk_out != $past(blk_in)));

  assert_done_after_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    inc_done |-> $past(inc_req));
endmodule

// File: tb/ctr_block_incr_tb.sv
module ctr_block_incr_tb;
  logic         clk;
  logic         rst_n;
  logic [127:0] blk_in;
  logic [2:0]   ctr_size;
  logic         ctr_right;
  logic         ctr_big;
  logic         inc_req;
  logic [127:0] blk_out;
  logic         inc_done;

  int checks = 0;
  int errors = 0;
  logic [127:0] exp_q[$];
  string        tag_q[$];
  logic [127:0] last_out;

  ctr_block_incr u_dut (
    .clk(clk), .rst_n(rst_n), .blk_in(blk_in), .ctr_size(ctr_size),
    .ctr_right(ctr_right), .ctr_big(ctr_big), .inc_req(inc_req),
    .blk_out(blk_out), .inc_done(inc_done)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // reference: walk octets from least to most significant
  function automatic logic [127:0] model(input logic [127:0] v, input logic [2:0] sz,
                                         input logic rt, input logic be);
    int n, lo, idx;
    logic [127:0] r;
    r = v;
    case (sz)
      3'd1: n = 1; 3'd2: n = 2; 3'd3: n = 4; 3'd4: n = 8; 3'd5: n = 16;
      default: n = 0;
    endcase
    lo = (rt && n < 16) ? 16 - n : 0;
    for (int k = 0; k < n; k++) begin
      idx = be ? lo + n - 1 - k : lo + k;
      r[idx*8 +: 8] = r[idx*8 +: 8] + 8'd1;
      if (r[idx*8 +: 8] != 8'd0) break;
    end
    return r;
  endfunction

  function automatic string req_tag(input logic [2:0] sz, input logic rt, input logic be);
    string s;
    if (sz == 3'd5) s = "R5";
    else if (rt) s = "R4";
    else s = "R3";
    s = {s, be ? "/R7" : "/R6", "/R1/R8"};
    return s;
  endfunction

  task automatic drive(input logic [127:0] v, input logic [2:0] sz, input logic rt, input logic be);
    @(negedge clk);
    blk_in = v; ctr_size = sz; ctr_right = rt; ctr_big = be; inc_req = 1'b1;
    if (sz >= 3'd1 && sz <= 3'd5) begin
      exp_q.push_back(model(v, sz, rt, be));
      tag_q.push_back(req_tag(sz, rt, be));
      last_out = model(v, sz, rt, be);
      @(negedge clk);
      inc_req = 1'b0;
    end else begin
      @(negedge clk);
      inc_req = 1'b0;
      checks++;
      if (inc_done !== 1'b0 || blk_out !== last_out) begin
        errors++;
        $display("FAIL R2 size=%0d done=%b out=%h expected done=0 out=%h",
                 sz, inc_done, blk_out, last_out);
      end
    end
  endtask

  // monitor: compare each done result against the scoreboard (R9 timing)
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && inc_done) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R9 done without request out=%h expected no done", blk_out);
        end else begin
          logic [127:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (blk_out !== e) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", t, blk_out, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; blk_in = '0; ctr_size = '0; ctr_right = 1'b0; ctr_big = 1'b0; inc_req = 1'b0;
    last_out = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (blk_out !== '0 || inc_done !== 1'b0) begin
      errors++;
      $display("FAIL R10 out=%h done=%b expected out=0 done=0", blk_out, inc_done);
    end
    rst_n = 1'b1;
    // every size code, alignment and endianness, with wrap and carry patterns (R8)
    for (int sz = 0; sz < 8; sz++) begin
      for (int rt = 0; rt < 2; rt++) begin
        for (int be = 0; be < 2; be++) begin
          drive({$urandom, $urandom, $urandom, $urandom}, 3'(sz), 1'(rt), 1'(be));
          drive({128{1'b1}}, 3'(sz), 1'(rt), 1'(be));
          drive(128'h00ff_00ff_ffff_ffff_ffff_ff00_ffff_ffff, 3'(sz), 1'(rt), 1'(be));
          drive(128'hffff_fffe_ff12_ffff_7fff_ffff_ffff_ffff, 3'(sz), 1'(rt), 1'(be));
        end
      end
    end
    // back-to-back strobes (R9)
    @(negedge clk);
    blk_in = 128'h0123_4567_89ab_cdef_0011_2233_4455_66ff;
    ctr_size = 3'd2; ctr_right = 1'b0; ctr_big = 1'b0; inc_req = 1'b1;
    exp_q.push_back(model(blk_in, 3'd2, 1'b0, 1'b0)); tag_q.push_back("R9/R6");
    @(negedge clk);
    ctr_size = 3'd3; ctr_right = 1'b1; ctr_big = 1'b1;
    exp_q.push_back(model(blk_in, 3'd3, 1'b1, 1'b1)); tag_q.push_back("R9/R7");
    last_out = model(blk_in, 3'd3, 1'b1, 1'b1);
    @(negedge clk);
    inc_req = 1'b0;
    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R9 pending=%0d expected 0", exp_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule